// File: doc/BRIEF.md
# Hardware-Monitor Alert and Intrusion Signaling Unit

This block turns three monitor conditions into board-level signals: an over-temperature event drives an active-low thermal pin, an alert event drives a general alert pin, and a chassis-intrusion input sets a sticky status flag. The unit can also ring a beeper and raise a wake request. Software configures it through a small indexed register port. Each write is captured on the clock edge while the write strobe is high. Reads are combinational from the index.

The two output pins each take a 2-bit mode. The choices are a plain level, a second style (a timed low pulse for the thermal pin, an active-high level for the alert pin), a 1 Hz blink, or a beeper tone. The tone alternates between 400 Hz and 800 Hz in 250 ms segments. All timing comes from counters sized by a clock-frequency parameter. The intrusion flag stays set until software writes 1 to it, and that write only takes effect once the intrusion input has gone away.

Top module: `hwmon_alert_out`

## Requirements
- R1: After reset the configuration register (index 0x02) and the status register (index 0x03) both read 0x00, both pins are high, and beepOut and pmeReq are low.
- R2: All eight bits of index 0x02 are read/write, including the spare bits 7 and 3. A read of any index other than 0x02 or 0x03 returns 0x00, and a write to such an index changes nothing.
- R3: Mode field 00 is level mode. The thermal field is bits 5:4 of index 0x02 and the alert field is bits 1:0. In level mode the pin is low exactly while its event input is high, and high otherwise.
- R4: Alert field 01 drives alertPin high exactly while alertEvent is high, and low otherwise.
- R5: Thermal field 01 is pulse mode. When the clock edge first samples ovtEvent high after it was low, ovtPinN goes low for exactly PULSE_CYC cycles starting after that edge. A held event gives no further pulse, and each new rising edge gives a new pulse.
- R6: Field 10 is blink mode. While the event is high, the pin is low for CLK_HZ/2 cycles and then high for CLK_HZ/2 cycles, repeating, with the count starting when the event rises. The pin is high while the event is low.
- R7: Field 11 is tone mode. The pin stays high, and beepOut carries a square wave while the event is high. The wave starts high with a half-period of CLK_HZ/800 cycles for CLK_HZ/4 cycles, then switches to a half-period of CLK_HZ/1600 for the same span, and keeps alternating. beepOut is low when no tone source is active.
- R8: Status bit 0 of index 0x03 becomes 1 on the clock edge after caseOpen is sampled high, and then stays 1. Bits 7:1 of index 0x03 always read 0.
- R9: A write to index 0x03 with bit 0 set clears the status bit only if caseOpen is low on that edge. A write with bit 0 clear has no effect, and a clearing write made while caseOpen is high leaves the bit set.
- R10: When bit 6 of index 0x02 is 1 and the status bit is set, beepOut carries the R7 tone.
- R11: pmeReq is high exactly while the status bit is set and bit 2 of index 0x02 is 1.
- R12: When several tone sources are active at once, beepOut is the OR of their tones. The tone keeps running without a break while at least one source stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ovtEvent | input | 1 | Over-temperature condition |
| alertEvent | input | 1 | Alert condition |
| caseOpen | input | 1 | Chassis intrusion condition |
| regIdx | input | 8 | Register index |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe |
| regRdData | output | 8 | Read data for regIdx |
| ovtPinN | output | 1 | Thermal signal pin |
| alertPin | output | 1 | Alert signal pin |
| beepOut | output | 1 | Beeper drive |
| pmeReq | output | 1 | Wake request level |

## Verification
The hardest case to reach is a tone that runs across a change of source. One source must hand the beeper to another without the tone generator resetting, and only the tone phase shows whether this happened. The bench starts the alert tone and an intrusion together, then removes the alert event mid-tone. It predicts every sample from a single running cycle count through both phases. The second hard case is a clearing write made while the intrusion input is still high. The bench drives caseOpen and the clearing write on the same edge.

// File: rtl/sigout_pkg.sv
package sigout_pkg;
  typedef enum logic [1:0] {
    PM_LEVEL = 2'b00,
    PM_ALT   = 2'b01,
    PM_BLINK = 2'b10,
    PM_TONE  = 2'b11
  } pinMode_t;

  typedef struct packed {
    pinMode_t ovtMode;
    pinMode_t alertMode;
    logic     caseBeep;
    logic     pulseStart;
  } ctrlStrobes_t;
endpackage

// File: rtl/sigout_ctrl.sv
module sigout_ctrl
  import sigout_pkg::*;
#(
  parameter logic [7:0] MODE_IDX   = 8'h02,
  parameter logic [7:0] STATUS_IDX = 8'h03
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ovtEvent,
  input  logic         caseOpen,
  input  logic [7:0]   regIdx,
  input  logic [7:0]   regWrData,
  input  logic         regWrEn,
  output logic [7:0]   regRdData,
  output ctrlStrobes_t strb,
  output logic [7:0]   modeReg,
  output logic         caseSts,
  output logic         pmeReq
);
  logic ovtPrev;
  logic clrReq;

  assign clrReq = regWrEn && (regIdx == STATUS_IDX) && regWrData[0] && !caseOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      caseSts <= 1'b0;
      ovtPrev <= 1'b0;
    end else begin
      ovtPrev <= ovtEvent;
      if (regWrEn && regIdx == MODE_IDX) modeReg <= regWrData;
      // intrusion sets with priority over any clearing write
      if (caseOpen)    caseSts <= 1'b1;
      else if (clrReq) caseSts <= 1'b0;
    end
  end

  always_comb begin
    if (regIdx == MODE_IDX)        regRdData = modeReg;
    else if (regIdx == STATUS_IDX) regRdData = {7'b0, caseSts};
    else                           regRdData = 8'h00;
  end

  always_comb begin
    strb.ovtMode    = pinMode_t'(modeReg[5:4]);
    strb.alertMode  = pinMode_t'(modeReg[1:0]);
    strb.caseBeep   = modeReg[6] && caseSts;
    strb.pulseStart = ovtEvent && !ovtPrev && (pinMode_t'(modeReg[5:4]) == PM_ALT);
  end

  assign pmeReq = caseSts && modeReg[2];
endmodule

// File: rtl/sigout_dp.sv
module sigout_dp
  import sigout_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PULSE_CYC = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic         ovtEvent,
  input  logic         alertEvent,
  output logic         ovtPinN,
  output logic         alertPin,
  output logic         beepOut
);
  localparam int BLINK_FULL = 2 * (CLK_HZ / 2);
  localparam int LO_HALF    = CLK_HZ / 800;
  localparam int HI_HALF    = CLK_HZ / 1600;
  localparam int SEG_CYC    = CLK_HZ / 4;
  localparam int BW = $clog2(BLINK_FULL + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam int TW = $clog2(LO_HALF + 1);
  localparam int SW = $clog2(SEG_CYC + 1);
  localparam logic [BW-1:0] BLINK_LAST = BW'(BLINK_FULL - 1);
  localparam logic [BW-1:0] BLINK_HALF = BW'(CLK_HZ / 2);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC);
  localparam logic [TW-1:0] LO_LAST    = TW'(LO_HALF - 1);
  localparam logic [TW-1:0] HI_LAST    = TW'(HI_HALF - 1);
  localparam logic [SW-1:0] SEG_LAST   = SW'(SEG_CYC - 1);

  // per-pin blink generators (index 0 = thermal, 1 = alert)
  logic [1:0] pinEvt;
  logic [1:0] blinkOn;
  pinMode_t   pinMode [2];
  assign pinEvt     = {alertEvent, ovtEvent};
  assign pinMode[0] = strb.ovtMode;
  assign pinMode[1] = strb.alertMode;

  for (genvar i = 0; i < 2; i++) begin : g_blink
    logic [BW-1:0] blinkCnt;
    logic          blinkAct;
    assign blinkAct = pinEvt[i] && (pinMode[i] == PM_BLINK);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       blinkCnt <= '0;
      else if (!blinkAct)              blinkCnt <= '0;
      else if (blinkCnt == BLINK_LAST) blinkCnt <= '0;
      else                             blinkCnt <= blinkCnt + 1'b1;
    end
    assign blinkOn[i] = blinkAct && (blinkCnt < BLINK_HALF);
  end

  // thermal low pulse
  logic [PW-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseCnt <= '0;
    else if (strb.pulseStart) pulseCnt <= PULSE_LOAD;
    else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
  end

  // shared two-tone generator
  logic srcOvt, srcAlert, srcCase, toneAct;
  logic [TW-1:0] toneCnt;
  logic [SW-1:0] segCnt;
  logic          toneLvl, hiFreq;
  assign srcOvt   = ovtEvent && (strb.ovtMode == PM_TONE);
  assign srcAlert = alertEvent && (strb.alertMode == PM_TONE);
  assign srcCase  = strb.caseBeep;
  assign toneAct  = srcOvt || srcAlert || srcCase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneCnt <= '0; segCnt <= '0; toneLvl <= 1'b1; hiFreq <= 1'b0;
    end else if (!toneAct) begin
      toneCnt <= '0; segCnt <= '0; toneLvl <= 1'b1; hiFreq <= 1'b0;
    end else if (segCnt == SEG_LAST) begin
      segCnt  <= '0;
      toneCnt <= '0;
      toneLvl <= 1'b1;
      hiFreq  <= !hiFreq;
    end else begin
      segCnt <= segCnt + 1'b1;
      if (toneCnt == (hiFreq ? HI_LAST : LO_LAST)) begin
        toneCnt <= '0;
        toneLvl <= !toneLvl;
      end else begin
        toneCnt <= toneCnt + 1'b1;
      end
    end
  end

  assign beepOut = (srcOvt && toneLvl) || (srcAlert && toneLvl) || (srcCase && toneLvl);

  always_comb begin
    unique case (strb.ovtMode)
      PM_LEVEL: ovtPinN = !ovtEvent;
      PM_ALT:   ovtPinN = (pulseCnt == '0);
      PM_BLINK: ovtPinN = !blinkOn[0];
      PM_TONE:  ovtPinN = 1'b1;
    endcase
    unique case (strb.alertMode)
      PM_LEVEL: alertPin = !alertEvent;
      PM_ALT:   alertPin = alertEvent;
      PM_BLINK: alertPin = !blinkOn[1];
      PM_TONE:  alertPin = 1'b1;
    endcase
  end
endmodule

// File: rtl/hwmon_alert_out.sv
module hwmon_alert_out
  import sigout_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int PULSE_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovtEvent,
  input  logic       alertEvent,
  input  logic       caseOpen,
  input  logic [7:0] regIdx,
  input  logic [7:0] regWrData,
  input  logic       regWrEn,
  output logic [7:0] regRdData,
  output logic       ovtPinN,
  output logic       alertPin,
  output logic       beepOut,
  output logic       pmeReq
);
  ctrlStrobes_t strb;
  logic [7:0]   modeReg;
  logic         caseSts;

  sigout_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ovtEvent(ovtEvent), .caseOpen(caseOpen),
    .regIdx(regIdx), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData), .strb(strb), .modeReg(modeReg),
    .caseSts(caseSts), .pmeReq(pmeReq)
  );

  sigout_dp #(.CLK_HZ(CLK_HZ), .PULSE_CYC(PULSE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ovtEvent(ovtEvent),
    .alertEvent(alertEvent), .ovtPinN(ovtPinN), .alertPin(alertPin),
    .beepOut(beepOut)
  );
endmodule

// File: rtl/hwmon_alert_out_chk.sv
module hwmon_alert_out_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ovtEvent,
  input logic       alertEvent,
  input logic       caseOpen,
  input logic [7:0] regIdx,
  input logic [7:0] regWrData,
  input logic       regWrEn,
  input logic [7:0] regRdData,
  input logic       ovtPinN,
  input logic       alertPin,
  input logic       beepOut,
  input logic       pmeReq,
  input logic [7:0] modeReg,
  input logic       caseSts
);
  // R8
  case_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    caseOpen |=> caseSts);

  // R9
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (caseSts && !(regWrEn && regIdx == 8'h03 && regWrData[0])) |=> caseSts);

  // R8
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regIdx == 8'h03) |-> (regRdData[7:1] == 7'b0));

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b01 && ovtEvent && !$past(ovtEvent)) |=> !ovtPinN);

  // R7
  tone_rest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11) |-> ovtPinN);

  // R7
  beep_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!caseSts && !(alertEvent && modeReg[1:0] == 2'b11)
     && !(ovtEvent && modeReg[5:4] == 2'b11)) |-> !beepOut);

  // R11
  pme_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (caseOpen && modeReg[2] && !(regWrEn && regIdx == 8'h02)) |=> pmeReq);
endmodule

bind hwmon_alert_out hwmon_alert_out_chk u_chk (
  .clk(clk), .rstN(rstN), .ovtEvent(ovtEvent), .alertEvent(alertEvent),
  .caseOpen(caseOpen), .regIdx(regIdx), .regWrData(regWrData),
  .regWrEn(regWrEn), .regRdData(regRdData), .ovtPinN(ovtPinN),
  .alertPin(alertPin), .beepOut(beepOut), .pmeReq(pmeReq),
  .modeReg(modeReg), .caseSts(caseSts)
);

// File: tb/tb_hwmon_alert_out.sv
`timescale 1ns/1ps
module tb_hwmon_alert_out;
  localparam int CLK_HZ = 16000;  // scaled frequency parameter for short runs
  localparam int PULSE  = 5;
  localparam int BHALF  = CLK_HZ / 2;
  localparam int LOH    = CLK_HZ / 800;
  localparam int HIH    = CLK_HZ / 1600;
  localparam int SEG    = CLK_HZ / 4;

  logic clk = 0, rstN = 0;
  logic ovtEvent = 0, alertEvent = 0, caseOpen = 0, regWrEn = 0;
  logic [7:0] regIdx = 0, regWrData = 0, regRdData;
  logic ovtPinN, alertPin, beepOut, pmeReq;
  int nChk = 0, nFail = 0, beepN = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hwmon_alert_out #(.CLK_HZ(CLK_HZ), .PULSE_CYC(PULSE)) dut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    regIdx = idx; regWrData = d; regWrEn = 1;
    tick();
    regWrEn = 0;
  endtask

  task automatic rdChk(input logic [7:0] idx, input logic [7:0] exp, input string req);
    regIdx = idx; #1;
    chk(regRdData == exp, req, regRdData, exp);
  endtask

  function automatic bit expTone(input int n);
    int s = n / SEG, m = n % SEG, h;
    h = (s % 2 == 0) ? LOH : HIH;
    return ((m / h) % 2) == 0;
  endfunction

  // runs cyc cycles from the current beepN, one aggregated check
  task automatic beepRun(input int cyc, input string req);
    int badAct = -1, badExp = 0;
    for (int k = 0; k < cyc; k++) begin
      #1;
      if (badAct < 0 && beepOut != expTone(beepN)) begin
        badAct = beepOut; badExp = expTone(beepN);
      end
      tick(); beepN++;
    end
    chk(badAct < 0, req, badAct, badExp);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    rdChk(8'h02, 8'h00, "R1 mode reset");
    rdChk(8'h03, 8'h00, "R1 status reset");
    chk(ovtPinN && alertPin && !beepOut && !pmeReq, "R1 outputs",
        {ovtPinN, alertPin, beepOut, pmeReq}, 4'b1100);

    // R2 exhaustive read/write of the configuration register
    begin
      int bad = -1;
      for (int v = 0; v < 256; v++) begin
        wr(8'h02, 8'(v)); regIdx = 8'h02; #1;
        if (bad < 0 && regRdData != 8'(v)) bad = v;
      end
      chk(bad < 0, "R2 mode sweep", bad, 0);
    end
    wr(8'h02, 8'h00);
    wr(8'h05, 8'hA5);
    rdChk(8'h05, 8'h00, "R2 unmapped read");
    rdChk(8'h02, 8'h00, "R2 unmapped write ignored");

    // R3 / R4 level sweep
    for (int am = 0; am < 2; am++)
      for (int e = 0; e < 4; e++) begin
        ovtEvent = 0; alertEvent = 0;
        wr(8'h02, 8'(am));
        ovtEvent = e[0]; alertEvent = e[1]; #1;
        chk(ovtPinN == !e[0], "R3 ovt level", ovtPinN, !e[0]);
        chk(alertPin == (am ? e[1] : !e[1]), am ? "R4 alert high" : "R3 alert level",
            alertPin, am ? e[1] : !e[1]);
        tick();
      end
    ovtEvent = 0; alertEvent = 0;

    // R5 pulse mode
    wr(8'h02, 8'h10);
    tick();
    for (int rep = 0; rep < 2; rep++) begin
      ovtEvent = 1; #1;
      chk(ovtPinN == 1, "R5 no pulse before edge", ovtPinN, 1);
      for (int k = 1; k <= PULSE; k++) begin
        tick(); #1;
        chk(ovtPinN == 0, "R5 pulse low", ovtPinN, 0);
      end
      tick(); #1;
      chk(ovtPinN == 1, "R5 pulse end", ovtPinN, 1);
      repeat (20) tick(); #1;
      chk(ovtPinN == 1, "R5 held event single pulse", ovtPinN, 1);
      ovtEvent = 0; tick(); tick();
    end

    // R6 blink on both pins
    wr(8'h02, 8'h22);
    begin
      int bad = -1;
      ovtEvent = 1; alertEvent = 1;
      for (int n = 0; n < 2 * BHALF + 500; n++) begin
        #1;
        if (bad < 0 && (ovtPinN != !((n % (2 * BHALF)) < BHALF) ||
                        alertPin != !((n % (2 * BHALF)) < BHALF))) bad = n;
        tick();
      end
      chk(bad < 0, "R6 blink pattern", bad, -1);
      ovtEvent = 0; alertEvent = 0; #1;
      chk(ovtPinN && alertPin, "R6 blink idle", {ovtPinN, alertPin}, 2'b11);
    end

    // R7 thermal tone
    wr(8'h02, 8'h30);
    ovtEvent = 1; beepN = 0; #1;
    chk(ovtPinN == 1, "R7 pin rests", ovtPinN, 1);
    beepRun(2 * SEG + 200, "R7 tone pattern");
    ovtEvent = 0; #1;
    chk(beepOut == 0, "R7 tone stops", beepOut, 0);

    // R8 / R9 status
    wr(8'h02, 8'h00);
    caseOpen = 1; tick(); caseOpen = 0;
    rdChk(8'h03, 8'h01, "R8 status set");
    repeat (5) tick();
    rdChk(8'h03, 8'h01, "R8 status sticky");
    wr(8'h03, 8'hFE);
    rdChk(8'h03, 8'h01, "R9 write 0 no effect");
    caseOpen = 1;
    wr(8'h03, 8'h01);
    caseOpen = 0;
    rdChk(8'h03, 8'h01, "R9 clear blocked while open");
    wr(8'h03, 8'hFF);
    rdChk(8'h03, 8'h00, "R9 clear");

    // R11 wake request
    wr(8'h02, 8'h04);
    caseOpen = 1; tick(); caseOpen = 0; #1;
    chk(pmeReq == 1, "R11 pme set", pmeReq, 1);
    wr(8'h02, 8'h00); #1;
    chk(pmeReq == 0, "R11 pme routing off", pmeReq, 0);
    wr(8'h02, 8'h04); #1;
    chk(pmeReq == 1, "R11 pme routing on", pmeReq, 1);
    wr(8'h03, 8'h01); #1;
    chk(pmeReq == 0, "R11 pme after clear", pmeReq, 0);

    // R10 intrusion tone
    wr(8'h02, 8'h40);
    caseOpen = 1; tick(); caseOpen = 0;
    beepN = 0;
    beepRun(600, "R10 intrusion tone");
    wr(8'h02, 8'h00); #1;
    chk(beepOut == 0, "R10 routing off", beepOut, 0);
    wr(8'h03, 8'h01);

    // R12 two sources, hand-over without restart
    wr(8'h02, 8'h43);
    alertEvent = 1; caseOpen = 1; beepN = 0; #1;
    chk(alertPin == 1, "R12 alert pin rests in tone", alertPin, 1);
    beepRun(1, "R12 start");
    caseOpen = 0;
    beepRun(300, "R12 both sources");
    alertEvent = 0;
    beepRun(300, "R12 intrusion continues");
    wr(8'h03, 8'h01); #1;
    chk(beepOut == 0, "R12 all sources gone", beepOut, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule